// File: doc/BRIEF.md
# Duty-Cycled Receiver Mode Controller

This block sequences a low-power radio receiver through four operating modes: sleep, start-up, bit-check and receive. The receiver normally runs a polling cycle. It sleeps for a programmable time, powers up its front end for a fixed start-up interval, and then opens a bit-check window. A passing bit check moves the receiver into receive mode. A failing check, or a window that closes without a result, sends it back to sleep for a new period.

A host can override the polling cycle with one active-low control input. Pulling the input low wakes the receiver at once and leads it through start-up into receive mode, whatever sleep time is programmed. Releasing the input after a sufficiently long low period returns the receiver to polling after a fixed delay. The sleep-time code is an input from a register outside the block. It is not consulted while the override is active, and it is used again unchanged once polling resumes. The all-ones code makes sleep permanent while the control input is high, so a host can run the receiver purely by hand.

The control input is brought into the clock domain through a two-flop synchronizer. Radio start-up time is modelled as a counted delay.

Top module: `rx_poll_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mode is sleep. Mode encoding: 0 sleep, 1 start-up, 2 bit-check, 3 receive.
- R2: With the control input high and a sleep code C below all-ones, a sleep period lasts C*SLEEP_TICK+1 cycles and is followed by start-up. Start-up lasts STARTUP_CYC cycles and is followed by bit-check.
- R3: With the sleep code at all ones (31 for a 5-bit code) and the control input high, the receiver stays in sleep indefinitely.
- R4: A low level on the control input moves the receiver from sleep to start-up on the third clock edge after the fall, whatever the sleep code, including all ones. If the input is still low when start-up completes, the next mode is receive. A low input during bit-check also moves the receiver to receive.
- R5: After the control input has been low for at least MIN_LOW synchronized cycles, a rising edge returns the receiver to sleep on the (OFF_DELAY+3)th clock edge after the rise. A shorter low pulse leaves the receive mode unchanged.
- R6: In bit-check, bcValid high with bcPass high at a clock edge moves the receiver to receive on that edge. Receive then persists while the control input stays high.
- R7: In bit-check, bcValid high with bcPass low moves the receiver to sleep on that edge. If no result arrives within BITCHK_CYC cycles, the receiver also returns to sleep.
- R8: Every entry into sleep starts a fresh period counted from zero against the code present. A code held across an override episode therefore gives the same sleep length afterwards as before.
- R9: rfOn is high in every mode except sleep. bitCheckEn is high only in bit-check. dataEn is high only in receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlN | input | 1 | Active-low override input, asynchronous to clk |
| sleepCode | input | CODE_W | Sleep-time code; all ones selects permanent sleep |
| bcValid | input | 1 | Bit-check result valid strobe |
| bcPass | input | 1 | Bit-check result, 1 = pass |
| mode | output | 2 | Current mode (0 sleep, 1 start-up, 2 bit-check, 3 receive) |
| rfOn | output | 1 | Front end powered |
| bitCheckEn | output | 1 | Bit-check window open |
| dataEn | output | 1 | Data path active (receive mode) |

## Verification
The bench builds the block with SLEEP_TICK=4, STARTUP_CYC=5, BITCHK_CYC=6, MIN_LOW=4 and OFF_DELAY=3. With these values a full sleep, start-up and bit-check round takes a few dozen cycles, so thousands of random cycles pass through every mode transition many times. The same values also make the saturating sleep counter under the permanent code reach its cap within a directed test. Short control pulses, drawn both below and above the four-cycle minimum, check both the rejected and the accepted return-to-polling paths. Sleep codes are drawn from 0, 1, 2, 3 and 31, which covers zero-length sleep, ordinary sleep and permanent sleep.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_CHECK   = 2'd2,
    MODE_RECEIVE = 2'd3
  } rxMode_e;

  // strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic clrSleep;
    logic incSleep;
    logic clrPhase;
    logic incPhase;
  } dpStrobe_t;

endpackage

// File: rtl/rx_poll_datapath.sv
module rx_poll_datapath
  import rx_poll_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int SLEEP_TICK = 1024,
  parameter int PHASE_W    = 8,
  parameter int MIN_LOW    = 16,
  parameter int OFF_DELAY  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlN,
  input  logic [CODE_W-1:0]  sleepCode,
  input  dpStrobe_t          strobe,
  output logic               pinLow,
  output logic               sleepDone,
  output logic               permCode,
  output logic               offFire,
  output logic [PHASE_W-1:0] phaseCnt
);

  localparam int SLP_W = CODE_W + $clog2(SLEEP_TICK + 1);
  localparam int LOW_W = $clog2(MIN_LOW + 1);
  localparam int OFF_W = $clog2(OFF_DELAY + 1);
  localparam logic [CODE_W-1:0] PERM = {CODE_W{1'b1}};

  logic syncA, syncB, syncPrev;
  logic [LOW_W-1:0] lowCnt;
  logic offPend;
  logic [OFF_W-1:0] offCnt;
  logic [SLP_W-1:0] sleepCnt;
  logic [SLP_W-1:0] sleepLimit;
  logic pinRise;
  logic lowLongEnough;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      syncA    <= ctrlN;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign pinLow        = ~syncB;
  assign pinRise       = syncB & ~syncPrev;
  assign lowLongEnough = (lowCnt == LOW_W'(MIN_LOW));

  // saturating count of synchronized low cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (syncB)         lowCnt <= '0;
    else if (!lowLongEnough) lowCnt <= lowCnt + 1'b1;
  end

  // return-to-polling delay after an accepted release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offPend <= 1'b0;
      offCnt  <= '0;
    end else if (pinLow) begin
      offPend <= 1'b0;
    end else if (pinRise && lowLongEnough) begin
      offPend <= 1'b1;
      offCnt  <= OFF_W'(OFF_DELAY - 1);
    end else if (offPend) begin
      if (offCnt == '0) offPend <= 1'b0;
      else              offCnt  <= offCnt - 1'b1;
    end
  end

  assign offFire = offPend && (offCnt == '0);

  // sleep period counter, compared live against the programmed code
  assign sleepLimit = SLP_W'(sleepCode) * SLP_W'(SLEEP_TICK);
  assign sleepDone  = (sleepCnt >= sleepLimit);
  assign permCode   = (sleepCode == PERM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sleepCnt <= '0;
    else if (strobe.clrSleep) sleepCnt <= '0;
    else if (strobe.incSleep) sleepCnt <= sleepCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (strobe.clrPhase) phaseCnt <= '0;
    else if (strobe.incPhase) phaseCnt <= phaseCnt + 1'b1;
  end

  // R5: a release after too short a low period never arms the delay
  a_r5_short_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (pinRise && !lowLongEnough && !offPend) |=> !offPend);

  // R5: a new low level cancels a pending return
  a_r5_low_cancels: assert property (@(posedge clk) disable iff (!rstN)
    pinLow |=> !offPend);

  // R8: each sleep entry restarts the period from zero
  a_r8_fresh_period: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrSleep |=> (sleepCnt == '0));

endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
#(
  parameter int PHASE_W     = 8,
  parameter int STARTUP_CYC = 256,
  parameter int BITCHK_CYC  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinLow,
  input  logic               sleepDone,
  input  logic               permCode,
  input  logic               offFire,
  input  logic [PHASE_W-1:0] phaseCnt,
  input  logic               bcValid,
  input  logic               bcPass,
  output dpStrobe_t          strobe,
  output rxMode_e            state
);

  localparam logic [PHASE_W-1:0] STARTUP_LAST = PHASE_W'(STARTUP_CYC - 1);
  localparam logic [PHASE_W-1:0] CHECK_LAST   = PHASE_W'(BITCHK_CYC - 1);

  rxMode_e nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (offFire) begin
      nextState       = MODE_SLEEP;
      strobe.clrSleep = 1'b1;
    end else begin
      case (state)
        MODE_SLEEP: begin
          if (pinLow || (!permCode && sleepDone)) begin
            nextState       = MODE_STARTUP;
            strobe.clrPhase = 1'b1;
          end else if (!sleepDone) begin
            strobe.incSleep = 1'b1;
          end
        end
        MODE_STARTUP: begin
          if (phaseCnt == STARTUP_LAST) begin
            if (pinLow) begin
              nextState = MODE_RECEIVE;
            end else begin
              nextState       = MODE_CHECK;
              strobe.clrPhase = 1'b1;
            end
          end else begin
            strobe.incPhase = 1'b1;
          end
        end
        MODE_CHECK: begin
          if (pinLow || (bcValid && bcPass)) begin
            nextState = MODE_RECEIVE;
          end else if (bcValid || (phaseCnt == CHECK_LAST)) begin
            nextState       = MODE_SLEEP;
            strobe.clrSleep = 1'b1;
          end else begin
            strobe.incPhase = 1'b1;
          end
        end
        default: nextState = MODE_RECEIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_SLEEP;
    else       state <= nextState;
  end

  // R4: override wakes the receiver regardless of the sleep code
  a_r4_forced_wake: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SLEEP && pinLow && !offFire) |=> (state == MODE_STARTUP));

  // R3: permanent code keeps the receiver asleep while the input is high
  a_r3_perm_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SLEEP && permCode && !pinLow && !offFire) |=> (state == MODE_SLEEP));

  // R6: a passing check enters receive mode
  a_r6_pass_receive: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_CHECK && bcValid && bcPass && !offFire) |=> (state == MODE_RECEIVE));

  // R7: a failing check returns to sleep
  a_r7_fail_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_CHECK && bcValid && !bcPass && !pinLow && !offFire) |=> (state == MODE_SLEEP));

  // R6: receive persists until a return to polling fires
  a_r6_receive_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_RECEIVE && !offFire) |=> (state == MODE_RECEIVE));

endmodule

// File: rtl/rx_poll_ctrl.sv
module rx_poll_ctrl
  import rx_poll_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int SLEEP_TICK  = 1024,
  parameter int STARTUP_CYC = 256,
  parameter int BITCHK_CYC  = 64,
  parameter int MIN_LOW     = 16,
  parameter int OFF_DELAY   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlN,
  input  logic [CODE_W-1:0] sleepCode,
  input  logic              bcValid,
  input  logic              bcPass,
  output logic [1:0]        mode,
  output logic              rfOn,
  output logic              bitCheckEn,
  output logic              dataEn
);

  localparam int PHASE_MAX = (STARTUP_CYC > BITCHK_CYC) ? STARTUP_CYC : BITCHK_CYC;
  localparam int PHASE_W   = (PHASE_MAX < 2) ? 1 : $clog2(PHASE_MAX);

  dpStrobe_t          strobe;
  rxMode_e            state;
  logic               pinLow, sleepDone, permCode, offFire;
  logic [PHASE_W-1:0] phaseCnt;

  rx_poll_datapath #(
    .CODE_W(CODE_W), .SLEEP_TICK(SLEEP_TICK), .PHASE_W(PHASE_W),
    .MIN_LOW(MIN_LOW), .OFF_DELAY(OFF_DELAY)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrlN(ctrlN), .sleepCode(sleepCode),
    .strobe(strobe), .pinLow(pinLow), .sleepDone(sleepDone),
    .permCode(permCode), .offFire(offFire), .phaseCnt(phaseCnt)
  );

  rx_poll_fsm #(
    .PHASE_W(PHASE_W), .STARTUP_CYC(STARTUP_CYC), .BITCHK_CYC(BITCHK_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .pinLow(pinLow), .sleepDone(sleepDone),
    .permCode(permCode), .offFire(offFire), .phaseCnt(phaseCnt),
    .bcValid(bcValid), .bcPass(bcPass), .strobe(strobe), .state(state)
  );

  assign mode       = state;
  assign rfOn       = (state != MODE_SLEEP);
  assign bitCheckEn = (state == MODE_CHECK);
  assign dataEn     = (state == MODE_RECEIVE);

  // R9: at most one of the window and data enables is high
  a_r9_enable_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bitCheckEn, dataEn}));

  // R1: the cycle after reset release is spent in sleep
  a_r1_reset_sleep: assert property (@(posedge clk)
    $rose(rstN) |-> (mode == 2'd0));

endmodule

// File: tb/tb_rx_poll_ctrl.sv
module tb_rx_poll_ctrl;

  localparam int CODE_W = 5, TICK = 4, SUC = 5, BCC = 6, MINL = 4, OFFD = 3;

  logic clk = 0, rstN = 0, ctrlN = 1, bcValid = 0, bcPass = 0;
  logic [CODE_W-1:0] sleepCode = 5'd2;
  logic [1:0] mode;
  logic rfOn, bitCheckEn, dataEn;

  int nChecks = 0, nFails = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  rx_poll_ctrl #(.CODE_W(CODE_W), .SLEEP_TICK(TICK), .STARTUP_CYC(SUC),
    .BITCHK_CYC(BCC), .MIN_LOW(MINL), .OFF_DELAY(OFFD)) dut (
    .clk(clk), .rstN(rstN), .ctrlN(ctrlN), .sleepCode(sleepCode),
    .bcValid(bcValid), .bcPass(bcPass), .mode(mode), .rfOn(rfOn),
    .bitCheckEn(bitCheckEn), .dataEn(dataEn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference built from the requirements
  bit ms1, ms2, ms3, mpend, pl, rise, fire, sdone, perm;
  int mlow, moff, mscnt, mpcnt, mst, nst, lim;
  bit clrS, incS, clrP, incP;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ms1 = 1; ms2 = 1; ms3 = 1; mpend = 0; mlow = 0; moff = 0;
      mscnt = 0; mpcnt = 0; mst = 0;
    end else begin
      pl = !ms2; rise = ms2 && !ms3; fire = mpend && (moff == 0);
      lim = int'(sleepCode) * TICK; sdone = (mscnt >= lim); perm = (sleepCode == 5'd31);
      nst = mst; clrS = 0; incS = 0; clrP = 0; incP = 0;
      if (fire) begin nst = 0; clrS = 1; end
      else if (mst == 0) begin
        if (pl || (!perm && sdone)) begin nst = 1; clrP = 1; end
        else if (!sdone) incS = 1;
      end else if (mst == 1) begin
        if (mpcnt == SUC - 1) begin
          if (pl) nst = 3; else begin nst = 2; clrP = 1; end
        end else incP = 1;
      end else if (mst == 2) begin
        if (pl || (bcValid && bcPass)) nst = 3;
        else if (bcValid || mpcnt == BCC - 1) begin nst = 0; clrS = 1; end
        else incP = 1;
      end
      if (pl) mpend = 0;
      else if (rise && mlow == MINL) begin mpend = 1; moff = OFFD - 1; end
      else if (mpend) begin if (moff == 0) mpend = 0; else moff--; end
      if (ms2) mlow = 0; else if (mlow != MINL) mlow++;
      ms3 = ms2; ms2 = ms1; ms1 = ctrlN;
      if (clrS) mscnt = 0; else if (incS) mscnt++;
      if (clrP) mpcnt = 0; else if (incP) mpcnt++;
      mst = nst;
    end
  end

  always @(negedge clk) begin
    if (rstN && !doneFlag)
      chk(int'(mode) == mst, "R6 R7 R8 cycle model", int'(mode), mst);
  end

  // ---------------- helpers
  task automatic countWhile(input int m, output int n);
    n = 0;
    while (int'(mode) == m && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wakeToCheck();
    int n;
    countWhile(0, n);
    countWhile(1, n);
  endtask

  task automatic releaseLong();
    ctrlN = 0;
    repeat (10) @(negedge clk);
    ctrlN = 1;
    repeat (OFFD + 2) @(negedge clk);
    chk(mode == 2'd3, "R5 still receive before delay", mode, 3);
    @(negedge clk);
    chk(mode == 2'd0, "R5 back to sleep after delay", mode, 0);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- directed and random stimulus
  initial begin
    int n, hold;
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    chk(mode == 2'd0, "R1 reset mode", mode, 0);
    chk(rfOn == 0 && dataEn == 0 && bitCheckEn == 0, "R1 reset enables", {rfOn, dataEn, bitCheckEn}, 0);
    rstN = 1;
    chk(mode == 2'd0, "R1 first cycle after reset", mode, 0);

    countWhile(0, n); chk(n == 2 * TICK + 1, "R2 sleep length", n, 2 * TICK + 1);
    chk(rfOn == 1 && bitCheckEn == 0, "R9 startup enables", {rfOn, bitCheckEn}, 2);
    countWhile(1, n); chk(n == SUC, "R2 startup length", n, SUC);
    chk(bitCheckEn == 1 && dataEn == 0, "R9 check enables", {bitCheckEn, dataEn}, 2);
    countWhile(2, n); chk(n == BCC, "R7 check timeout length", n, BCC);
    chk(mode == 2'd0, "R7 timeout to sleep", mode, 0);

    countWhile(0, n); chk(n == 2 * TICK + 1, "R8 fresh sleep period", n, 2 * TICK + 1);
    countWhile(1, n);
    bcValid = 1; bcPass = 0; @(negedge clk); bcValid = 0;
    chk(mode == 2'd0, "R7 failed check to sleep", mode, 0);

    wakeToCheck();
    @(negedge clk);
    bcValid = 1; bcPass = 1; @(negedge clk); bcValid = 0; bcPass = 0;
    chk(mode == 2'd3 && dataEn == 1, "R6 pass to receive", mode, 3);
    repeat (30) @(negedge clk);
    chk(mode == 2'd3, "R6 receive persists", mode, 3);

    ctrlN = 0; repeat (2) @(negedge clk); ctrlN = 1;
    repeat (25) @(negedge clk);
    chk(mode == 2'd3, "R5 short pulse ignored", mode, 3);

    releaseLong();
    countWhile(0, n); chk(n == 2 * TICK + 1, "R8 sleep length kept after override", n, 2 * TICK + 1);

    countWhile(1, n);
    bcValid = 1; bcPass = 1; @(negedge clk); bcValid = 0;
    sleepCode = 5'd31;
    releaseLong();
    repeat (300) @(negedge clk);
    chk(mode == 2'd0, "R3 permanent sleep holds", mode, 0);

    ctrlN = 0;
    repeat (2) @(negedge clk);
    chk(mode == 2'd0, "R4 synchronizer latency", mode, 0);
    @(negedge clk);
    chk(mode == 2'd1, "R4 forced wake from permanent sleep", mode, 1);
    repeat (SUC) @(negedge clk);
    chk(mode == 2'd3, "R4 startup then receive", mode, 3);
    repeat (6) @(negedge clk);
    ctrlN = 1;
    repeat (OFFD + 3) @(negedge clk);
    chk(mode == 2'd0, "R5 release returns to polling", mode, 0);
    sleepCode = 5'd1;

    hold = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (hold == 0) begin
        ctrlN = ($urandom % 100) >= 25;
        hold = ctrlN ? 1 + $urandom % 60 : 1 + $urandom % 9;
      end else hold--;
      bcValid = ($urandom % 5) == 0;
      bcPass  = $urandom % 2;
      if (($urandom % 200) == 0) begin
        case ($urandom % 5)
          0: sleepCode = 5'd0;
          1: sleepCode = 5'd1;
          2: sleepCode = 5'd3;
          3: sleepCode = 5'd31;
          default: sleepCode = 5'd2;
        endcase
      end
    end

    @(negedge clk);
    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule